// File: doc/BRIEF.md
# Low-Voltage Detect Status and Control Register

This block is one byte-wide power-management register placed on a simple synchronous bus. Through it, software sets up a low-voltage detector and watches it. An asynchronous comparator output is brought into the clock domain through a synchronizer chain. Once detection is active, a rising supply fault sets a sticky flag. That flag can raise an interrupt request, a reset request, or both, depending on the enables software has chosen.

Detection is gated by a master enable and by a STOP-mode input. The stop enable decides whether detection keeps running while the chip is in STOP. The reset-request enable and the master enable are protected: only the first write after reset can change them, and any later write leaves them as they are. A separate bandgap buffer enable is driven straight to an output for the converter that uses it.

Top module: `lvd_status_ctrl`

## Requirements
- R1: After reset, a read returns 0x1C. The reset enable, stop enable and master enable are 1, and every other bit is 0.
- R2: The bit positions are: flag bit 7, acknowledge bit 6, interrupt enable bit 5, reset enable bit 4, stop enable bit 3, master enable bit 2, reserved bit 1, bandgap buffer enable bit 0. The interrupt enable, stop enable and bandgap enable take every write. `bgBufEn` follows bit 0.
- R3: While detection is active, a high comparator input sets the flag SYNC_STAGES+1 clock edges after it is sampled. The flag stays at 1 after the input falls.
- R4: A write with bit 6 at 1 clears the flag. A write with bit 6 at 0 leaves the flag unchanged. Bit 6 always reads as 0.
- R5: If a set condition and an acknowledge write occur on the same edge, the flag ends at 1.
- R6: `irqReq` is 1 exactly when the interrupt enable is 1 and the flag reads as 1.
- R7: `rstReq` is 1 exactly when the reset enable, the master enable and the flag are all 1.
- R8: While `stopMode` is 1, detection runs only if the stop enable is 1. With the stop enable at 0, the comparator cannot set the flag in STOP.
- R9: Only the first write after reset can change the reset enable and the master enable. Every write, including a write that only acknowledges, locks them until the next reset.
- R10: Bit 1 always reads as 0, whatever value was written to it.
- R11: While the master enable is 0, the flag neither sets nor reads as 1, and neither request is raised. `detectEn` shows the master enable.
- R12: `rdData` is 0 unless both `sel` and `rdStb` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Address match for this register |
| wrStb | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdStb | input | 1 | Read strobe |
| rdData | output | 8 | Read data, combinational |
| lowVoltAsync | input | 1 | Asynchronous comparator output, high when the supply is low |
| stopMode | input | 1 | High while the chip is in STOP mode |
| irqReq | output | 1 | Interrupt request |
| rstReq | output | 1 | Reset request |
| detectEn | output | 1 | Detector enable |
| bgBufEn | output | 1 | Bandgap buffer enable |

## Verification
The bench uses the default SYNC_STAGES of 2, so a comparator edge reaches the flag within three cycles. This short latency lets the bench line up a set condition with an acknowledge write on the same edge without any wait. It also lets a STOP-mode window with the stop enable off run long enough to show that no set gets through. Two resets in the middle of the run put the register back in its unlocked state, which exposes both outcomes of the first write: one that leaves the master enable at 1 and one that turns it off for good.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int REG_W = 8;

  localparam int BIT_FLAG = 7;
  localparam int BIT_ACK  = 6;
  localparam int BIT_IE   = 5;
  localparam int BIT_RE   = 4;
  localparam int BIT_SE   = 3;
  localparam int BIT_EN   = 2;
  localparam int BIT_RSV  = 1;
  localparam int BIT_BG   = 0;

  localparam logic [REG_W-1:0] RESET_VAL = 8'h1C;

  typedef struct packed {
    logic wrAny;
    logic wrFirst;
    logic ackWr;
    logic rdEn;
  } ctl_strobes_t;
endpackage

// File: rtl/lvd_ctrl.sv
module lvd_ctrl
  import lvd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sel,
  input  logic         wrStb,
  input  logic         rdStb,
  input  logic         ackBit,
  output ctl_strobes_t strobes
);
  logic locked;
  logic wrHit;

  assign wrHit = sel & wrStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) locked <= 1'b0;
    else if (wrHit) locked <= 1'b1;
  end

  always_comb begin
    strobes.wrAny   = wrHit;
    strobes.wrFirst = wrHit & ~locked;
    strobes.ackWr   = wrHit & ackBit;
    strobes.rdEn    = sel & rdStb;
  end

  // R9: once any write has landed, the lock holds until reset
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> !strobes.wrFirst);
endmodule

// File: rtl/lvd_datapath.sv
module lvd_datapath
  import lvd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobes_t     strobes,
  input  logic [REG_W-1:0] wrData,
  input  logic             lowVoltAsync,
  input  logic             stopMode,
  output logic [REG_W-1:0] rdData,
  output logic             irqReq,
  output logic             rstReq,
  output logic             detectEn,
  output logic             bgBufEn
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic intEn, resetEn, stopEn, masterEn, bgEn, flag;
  logic detActive, setCond, flagVis;
  logic unusedWrBits;

  assign unusedWrBits = wrData[BIT_FLAG] ^ wrData[BIT_RSV] ^ wrData[BIT_ACK];

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : gSync
      if (gi == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= lowVoltAsync;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else       syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  assign detActive = masterEn & (~stopMode | stopEn);
  assign setCond   = detActive & syncChain[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               flag <= 1'b0;
    else if (setCond)        flag <= 1'b1;
    else if (strobes.ackWr)  flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn    <= RESET_VAL[BIT_IE];
      resetEn  <= RESET_VAL[BIT_RE];
      stopEn   <= RESET_VAL[BIT_SE];
      masterEn <= RESET_VAL[BIT_EN];
      bgEn     <= RESET_VAL[BIT_BG];
    end else if (strobes.wrAny) begin
      intEn  <= wrData[BIT_IE];
      stopEn <= wrData[BIT_SE];
      bgEn   <= wrData[BIT_BG];
      if (strobes.wrFirst) begin
        resetEn  <= wrData[BIT_RE];
        masterEn <= wrData[BIT_EN];
      end
    end
  end

  assign flagVis = flag & masterEn;

  always_comb begin
    rdData = '0;
    if (strobes.rdEn) begin
      rdData[BIT_FLAG] = flagVis;
      rdData[BIT_IE]   = intEn;
      rdData[BIT_RE]   = resetEn;
      rdData[BIT_SE]   = stopEn;
      rdData[BIT_EN]   = masterEn;
      rdData[BIT_BG]   = bgEn;
    end
  end

  assign irqReq   = intEn & flagVis;
  assign rstReq   = resetEn & flagVis;
  assign detectEn = masterEn;
  assign bgBufEn  = bgEn;

  // R3: flag is sticky without an acknowledge
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    flag && !strobes.ackWr |=> flag);
  // R5: active detection with the synchronized input high wins over an acknowledge
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    masterEn && (!stopMode || stopEn) && syncChain[LAST] |=> flag);
  // R8: STOP with the stop enable off cannot set the flag
  assert_stop_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopMode && !stopEn && !flag |=> !flag);
  // R9: locked writes leave the protected bits alone
  assert_locked_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrAny && !strobes.wrFirst |=> $stable(resetEn) && $stable(masterEn));
  // R11: detector off means the flag cannot rise
  assert_master_off_R11: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn && !flag |=> !flag);
endmodule

// File: rtl/lvd_status_ctrl.sv
module lvd_status_ctrl
  import lvd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sel,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  input  logic       rdStb,
  output logic [7:0] rdData,
  input  logic       lowVoltAsync,
  input  logic       stopMode,
  output logic       irqReq,
  output logic       rstReq,
  output logic       detectEn,
  output logic       bgBufEn
);
  ctl_strobes_t strobes;

  lvd_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .sel     (sel),
    .wrStb   (wrStb),
    .rdStb   (rdStb),
    .ackBit  (wrData[BIT_ACK]),
    .strobes (strobes)
  );

  lvd_datapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .wrData       (wrData),
    .lowVoltAsync (lowVoltAsync),
    .stopMode     (stopMode),
    .rdData       (rdData),
    .irqReq       (irqReq),
    .rstReq       (rstReq),
    .detectEn     (detectEn),
    .bgBufEn      (bgBufEn)
  );

  // R7: a reset request never appears with the detector off
  assert_rst_needs_en_R7: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> detectEn);
endmodule

// File: tb/tb_lvd_status_ctrl.sv
module tb_lvd_status_ctrl;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sel = 0, wrStb = 0, rdStb = 0, lowVoltAsync = 0, stopMode = 0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic irqReq, rstReq, detectEn, bgBufEn;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lvd_status_ctrl #(.SYNC_STAGES(N)) dut (
    .clk(clk), .rstN(rstN), .sel(sel), .wrStb(wrStb), .wrData(wrData),
    .rdStb(rdStb), .rdData(rdData), .lowVoltAsync(lowVoltAsync),
    .stopMode(stopMode), .irqReq(irqReq), .rstReq(rstReq),
    .detectEn(detectEn), .bgBufEn(bgBufEn)
  );

  // behavioural reference model
  bit mIe, mRe, mSe, mEn, mBg, mFlag, mLock;
  bit lvQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mIe = 0; mRe = 1; mSe = 1; mEn = 1; mBg = 0; mFlag = 0; mLock = 0;
      lvQ = {};
      repeat (N) lvQ.push_front(1'b0);
    end else begin
      bit wr, doSet;
      wr = sel && wrStb;
      doSet = mEn && (!stopMode || mSe) && lvQ[N-1];
      if (doSet) mFlag = 1;
      else if (wr && wrData[6]) mFlag = 0;
      if (wr) begin
        mIe = wrData[5]; mSe = wrData[3]; mBg = wrData[0];
        if (!mLock) begin mRe = wrData[4]; mEn = wrData[2]; end
        mLock = 1;
      end
      lvQ.push_front(lowVoltAsync);
      void'(lvQ.pop_back());
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    bit vis;
    int rdExp;
    @(negedge clk);
    vis = mFlag && mEn;
    rdExp = (sel && rdStb) ? {vis, 1'b0, mIe, mRe, mSe, mEn, 1'b0, mBg} : 0;
    chk(tag, "rdData", rdData, rdExp);
    chk(tag, "irqReq", irqReq, mIe && vis);
    chk(tag, "rstReq", rstReq, mRe && vis);
    chk(tag, "detectEn", detectEn, mEn);
    chk(tag, "bgBufEn", bgBufEn, mBg);
  endtask

  task automatic idle(); sel = 0; wrStb = 0; rdStb = 0; endtask
  task automatic wr(logic [7:0] d); sel = 1; wrStb = 1; rdStb = 0; wrData = d; endtask
  task automatic rd(); sel = 1; wrStb = 0; rdStb = 1; endtask

  task automatic doReset();
    @(negedge clk);
    idle(); lowVoltAsync = 0; stopMode = 0; rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    doReset();
    rd(); tick("R1");
    sel = 0; rdStb = 1; tick("R12");
    sel = 1; rdStb = 0; tick("R12");
    wr(8'h3F); tick("R2");
    rd(); tick("R10");
    wr(8'h02); tick("R9");
    rd(); tick("R9");
    wr(8'h21); tick("R2");
    idle(); lowVoltAsync = 1;
    for (int i = 0; i < 5; i++) tick("R3");
    lowVoltAsync = 0;
    for (int i = 0; i < 4; i++) tick("R6");
    rd(); tick("R7");
    wr(8'h21); tick("R4");
    rd(); tick("R4");
    wr(8'h61); tick("R4");
    rd(); tick("R4");
    idle(); lowVoltAsync = 1;
    for (int i = 0; i < 4; i++) tick("R3");
    wr(8'h61); tick("R5");
    rd(); tick("R5");
    idle(); lowVoltAsync = 0;
    for (int i = 0; i < 3; i++) tick("R3");
    wr(8'h60); tick("R4");
    idle(); stopMode = 1; lowVoltAsync = 1;
    for (int i = 0; i < 6; i++) tick("R8");
    rd(); tick("R8");
    wr(8'h28); tick("R8");
    idle();
    for (int i = 0; i < 3; i++) tick("R8");
    rd(); tick("R8");
    // second reset: first write turns the detector off
    doReset();
    wr(8'h00); tick("R11");
    idle(); lowVoltAsync = 1;
    for (int i = 0; i < 5; i++) tick("R11");
    wr(8'h34); tick("R9");
    rd(); tick("R11");
    // third reset: an acknowledge-only write still locks
    doReset();
    wr(8'h5C); tick("R9");
    wr(8'h20); tick("R9");
    rd(); tick("R9");
    idle(); tick("R12");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule